// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that guards against both a software hang and a refresh loop running too fast. A 7-bit counter counts down by one every `PRESCALE` clock cycles once the watchdog has been armed. When the count steps from 0x40 to 0x3F, the watchdog has expired and it raises a reset pulse.

Software keeps the system alive by rewriting the counter. A rewrite is accepted only when the current count has fallen to or below a programmable window threshold. A rewrite made while the count is still above the threshold is treated as a fault and also raises the reset pulse.

Arming is one-way: after the watchdog is enabled, it stays enabled until its own reset pulse or the system reset. The control word has two fields: bit 7 is the arm request and bits 6:0 are the new count. The threshold is written through a separate 7-bit port. The current count is visible on a read-back output.

Top module: `win_watchdog`

## Requirements
- R1: After `rst_n` is released, `wdg_rst_o` is low, `cnt_o` reads 0x7F, the window threshold is 0x7F and the watchdog is disarmed.
- R2: While disarmed, the count never changes on its own. A control write with bit 7 clear only loads bits 6:0 into the count and raises no reset pulse, even if bit 6 is clear.
- R3: While armed, the count drops by exactly one every `PRESCALE` cycles. Every accepted control write restarts this interval, so the first decrement happens `PRESCALE` cycles after the write edge.
- R4: When an armed count decrements from 0x40, `wdg_rst_o` rises at that same edge, so an armed count never reads with bit 6 clear.
- R5: A control write while armed is a refresh. If the count is above the window threshold, it is rejected and raises the reset pulse. If the count is equal to or below the threshold, the write loads the count with no pulse.
- R6: A control write that leaves the watchdog armed (bit 7 set, or already armed) but carries bit 6 of the count clear raises the reset pulse at the next edge.
- R7: Arming is sticky. A control write with bit 7 clear does not disarm an armed watchdog, and the countdown continues from the written value.
- R8: The reset pulse stays high for exactly `RST_CYC` cycles. When it fires, the block returns to the R1 state (disarmed, count 0x7F, threshold 0x7F).
- R9: Control and window writes made while the reset pulse is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_wdata | input | 8 | Bit 7 arm request, bits 6:0 count value |
| win_we | input | 1 | Window threshold write strobe |
| win_wdata | input | 7 | Window threshold value |
| cnt_o | output | 7 | Current count |
| wdg_rst_o | output | 1 | Reset pulse, active high |

## Verification
A corrupted prescaler or count shows on `cnt_o` within one `PRESCALE` interval, as a decrement that comes too early, too late or by the wrong step. A wrong arm state shows either as a count that moves while disarmed or as a missing expiry pulse, which appears at most 64 intervals later. A wrong window compare shows on `wdg_rst_o` at the edge just after the offending refresh.

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int PRESCALE = 12288,
  parameter int RST_CYC  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  input  logic       win_we,
  input  logic [6:0] win_wdata,
  output logic [6:0] cnt_o,
  output logic       wdg_rst_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
  localparam logic [6:0] CNT_INIT = 7'h7F;

  logic          en_q;
  logic [6:0]    cnt_q, win_q;
  logic [PW-1:0] pre_q;
  logic [CW-1:0] pulse_q;

  wire busy     = pulse_q != '0;
  wire tick     = en_q && (pre_q == PRE_LAST);
  wire en_next  = en_q | ctrl_wdata[7];
  wire early    = ctrl_we && en_q && (cnt_q > win_q);
  wire bad_load = ctrl_we && en_next && !ctrl_wdata[6];
  wire expire   = tick && !ctrl_we && (cnt_q == 7'h40);
  wire fire     = !busy && (early || bad_load || expire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cnt_q   <= CNT_INIT;
      win_q   <= CNT_INIT;
      pre_q   <= '0;
      pulse_q <= '0;
    end else if (fire) begin
      en_q    <= 1'b0;
      cnt_q   <= CNT_INIT;
      win_q   <= CNT_INIT;
      pre_q   <= '0;
      pulse_q <= CW'(RST_CYC);
    end else if (busy) begin
      pulse_q <= pulse_q - 1'b1;
    end else begin
      if (win_we) win_q <= win_wdata;
      if (ctrl_we) begin
        en_q  <= en_next;
        cnt_q <= ctrl_wdata[6:0];
        pre_q <= '0;
      end else if (en_q) begin
        pre_q <= tick ? '0 : pre_q + 1'b1;
        if (tick) cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign wdg_rst_o = busy;
endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_we,
  input logic [7:0] ctrl_wdata,
  input logic       en_q,
  input logic [6:0] cnt_q,
  input logic [6:0] win_q,
  input logic       wdg_rst_o
);
  assert_armed_bit6_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> cnt_q[6]);

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ctrl_we && !wdg_rst_o) |=> $stable(cnt_q));

  assert_early_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && en_q && !wdg_rst_o && (cnt_q > win_q)) |=> wdg_rst_o);

  assert_bad_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !wdg_rst_o && !ctrl_wdata[6] && (en_q || ctrl_wdata[7])) |=> wdg_rst_o);

  assert_sticky_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wdg_rst_o) |=> (en_q || wdg_rst_o));

  assert_pulse_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdg_rst_o) |=> wdg_rst_o);

  assert_pulse_disarms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst_o |-> (!en_q && cnt_q == 7'h7F && win_q == 7'h7F));
endmodule

bind win_watchdog win_watchdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
  .en_q(en_q), .cnt_q(cnt_q), .win_q(win_q), .wdg_rst_o(wdg_rst_o)
);

// File: tb/win_watchdog_tb.sv
module win_watchdog_tb;
  localparam int P  = 4;
  localparam int RC = 3;
  localparam int NV = 8;
  // {window, start count, ticks waited before refresh, early expected}
  localparam logic [31:0] VEC [NV] = '{
    {8'h50, 8'h60, 8'd5,  8'd1},
    {8'h50, 8'h60, 8'd16, 8'd0},
    {8'h50, 8'h60, 8'd15, 8'd1},
    {8'h7F, 8'h7F, 8'd3,  8'd0},
    {8'h45, 8'h7F, 8'd60, 8'd0},
    {8'h40, 8'h50, 8'd10, 8'd1},
    {8'h60, 8'h70, 8'd20, 8'd0},
    {8'h3F, 8'h41, 8'd0,  8'd1}
  };

  logic clk = 0, rst_n = 0, ctrl_we = 0, win_we = 0;
  logic [7:0] ctrl_wdata = 0;
  logic [6:0] win_wdata = 0;
  logic [6:0] cnt_o;
  logic wdg_rst_o;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  win_watchdog #(.PRESCALE(P), .RST_CYC(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .win_we(win_we), .win_wdata(win_wdata), .cnt_o(cnt_o), .wdg_rst_o(wdg_rst_o));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, act=%0d exp<=100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic drive_ctrl(input logic [7:0] d);
    ctrl_we = 1; ctrl_wdata = d;
    @(negedge clk) ctrl_we = 0;
  endtask

  task automatic drive_win(input logic [6:0] d);
    win_we = 1; win_wdata = d;
    @(negedge clk) win_we = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    do_reset();
    chk("R1 rst low", wdg_rst_o, 0);
    chk("R1 cnt init", cnt_o, 7'h7F);
    wait_cyc(40);
    chk("R2 disarmed stable", cnt_o, 7'h7F);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] w, c, t, e;
      {w, c, t, e} = VEC[i];
      do_reset();
      drive_win(w[6:0]);
      drive_ctrl(8'h80 | c);
      wait_cyc(int'(t) * P);
      chk("R3 decrement rate", cnt_o, int'(c) - int'(t));
      drive_ctrl(8'hFF);
      chk("R5 window refresh", wdg_rst_o, e);
      if (e == 0) chk("R5 refresh loads", cnt_o, 7'h7F);
    end

    // R4 timeout, R8 pulse, R9 ignore
    do_reset();
    drive_win(7'h50);
    drive_ctrl(8'hC2);
    wait_cyc(3 * P - 1);
    chk("R4 before expiry", wdg_rst_o, 0);
    chk("R4 count at 0x40", cnt_o, 7'h40);
    wait_cyc(1);
    chk("R4 expiry pulse", wdg_rst_o, 1);
    drive_ctrl(8'hFF);
    chk("R8 pulse 2nd", wdg_rst_o, 1);
    wait_cyc(1);
    chk("R8 pulse 3rd", wdg_rst_o, 1);
    wait_cyc(1);
    chk("R8 pulse ends", wdg_rst_o, 0);
    chk("R8 count restored", cnt_o, 7'h7F);
    wait_cyc(20);
    chk("R9 write during pulse ignored", cnt_o, 7'h7F);
    chk("R9 no rearm", wdg_rst_o, 0);
    drive_ctrl(8'hFF);
    drive_ctrl(8'hFF);
    chk("R8 window restored", wdg_rst_o, 0);

    // R7 sticky arm
    do_reset();
    drive_ctrl(8'hFF);
    drive_ctrl(8'h41);
    chk("R7 load with bit7 clear", cnt_o, 7'h41);
    wait_cyc(2 * P - 1);
    chk("R7 still counting", cnt_o, 7'h40);
    wait_cyc(1);
    chk("R7 still armed expires", wdg_rst_o, 1);

    // R6 bad load
    do_reset();
    drive_ctrl(8'hFF);
    drive_ctrl(8'h3F);
    chk("R6 armed bit6 clear", wdg_rst_o, 1);
    do_reset();
    drive_ctrl(8'hA0);
    chk("R6 arming bit6 clear", wdg_rst_o, 1);

    // R2 disarmed load
    do_reset();
    drive_ctrl(8'h20);
    chk("R2 disarmed load no pulse", wdg_rst_o, 0);
    chk("R2 disarmed load value", cnt_o, 7'h20);
    wait_cyc(30);
    chk("R2 disarmed hold", cnt_o, 7'h20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule